// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Applicator

This block applies corrections found by a Reed-Solomon decoder to a flash page held in a byte-wide, single-port store. The code works on 12-bit symbols, so each symbol covers one and a half bytes. A symbol's error pattern therefore lands on two bytes, split at a nibble. The store addresses the 2048 data bytes and the spare bytes that follow them as one linear space. Byte 2048 is spare byte 0, so a symbol near the end of the data region can reach across into the spare region with no special address arithmetic.

The decoder hands over up to four entries, each with a symbol index, a 12-bit pattern and a valid bit, plus an entry count and a failure flag. After a start pulse the block walks through the entries in order. It reads each affected byte, XORs in its part of the pattern and writes the byte back. It then raises done for one cycle. If the decode failed, or the correction cannot be applied, no byte is written and an uncorrectable flag is raised together with done.

The store is treated as an MSB-first bit stream. Symbol `p` occupies stream bits `12p-4` through `12p+7`, where stream bit `8k` is bit 7 of byte `k`. The four bits of symbol 0 that fall before the stream start carry no data.

Top module: `rs_err_apply`

## Requirements
- R1: For an odd index p, pattern bits 11:4 are XORed into byte floor(3p/2). Pattern bits 3:0 are XORed into bits 7:4 of the next byte.
- R2: For an even index p other than 0, pattern bits 11:8 are XORed into bits 3:0 of byte 3p/2-1. Pattern bits 7:0 are XORed into byte 3p/2.
- R3: Index 0 causes exactly one byte update. That update is to byte 0, with pattern bits 7:0. Pattern bits 11:8 are dropped.
- R4: The data and spare regions share one address space, with spare byte n at address 2048+n. Symbol 1365 updates bytes 2047 and 2048. Symbols 1366 and up land in the spare region under the same rules. No access goes to an address at or above 2048 plus the spare size.
- R5: An entry is applied only when its slot number is below the count and its valid bit is 1. Active entries are applied in slot order, and a count of 0 writes nothing.
- R6: The whole request is rejected if any of these holds: the failure flag is set, the count exceeds 4, or an active entry has an index above 1366. A rejected request writes no byte and drives uncorr_o high with done_o. Otherwise uncorr_o is low with done_o.
- R7: Every byte update is a read cycle followed directly by a write cycle to the same address. The write data is the read data XOR the mask. Read data arrives the cycle after the read.
- R8: The two bytes of one symbol are updated in ascending address order.
- R9: busy_o is high from the cycle after an accepted start until done_o. done_o is a single-cycle pulse. A start while busy is ignored.
- R10: After reset, busy_o, done_o, uncorr_o and mem_en_o are low.
- R11: No memory access happens while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| fail_i | input | 1 | Decoder reports failure |
| count_i | input | 4 | Number of entries supplied |
| loc_i | input | 44 | Four 11-bit symbol indices, slot 0 in the low bits |
| pat_i | input | 48 | Four 12-bit error patterns, slot 0 in the low bits |
| vld_i | input | 4 | Per-slot valid bits |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| uncorr_o | output | 1 | Request rejected, valid with done_o, held until next start |
| mem_en_o | output | 1 | Store access enable |
| mem_we_o | output | 1 | Store write enable, read when low |
| mem_addr_o | output | 12 | Linear byte address across data and spare regions |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after the read |

## Verification
The assertions assume that the decoder holds the count, entries, valid bits and failure flag stable while the block is busy. They also assume that the store returns read data exactly one cycle after a read. The bench models the store with that latency and changes the entry inputs only after done_o has dropped. Expected page contents come from the bit-stream view of the symbols, not from the per-byte rules. The touched bytes are logged in write order, which checks the update count for index 0 and the ascending order within each symbol.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  localparam int SYM_W  = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_RD_LO,
    ST_WR_LO,
    ST_RD_HI,
    ST_WR_HI,
    ST_DONE
  } rsa_state_e;
endpackage

// File: rtl/rsa_sym_map.sv
module rsa_sym_map
  import rsa_pkg::*;
#(
  parameter int IDX_W  = 11,
  parameter int ADDR_W = 12
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SYM_W-1:0]  pat_i,
  output logic [ADDR_W-1:0] lo_addr_o,
  output logic [BYTE_W-1:0] lo_mask_o,
  output logic [ADDR_W-1:0] hi_addr_o,
  output logic [BYTE_W-1:0] hi_mask_o,
  output logic              lo_skip_o
);
  // floor(3p/2) = p + floor(p/2)
  logic [IDX_W:0] base;
  assign base = {1'b0, idx_i} + {2'b00, idx_i[IDX_W-1:1]};

  always_comb begin
    if (idx_i[0]) begin
      lo_addr_o = ADDR_W'(base);
      lo_mask_o = pat_i[11:4];
      hi_addr_o = ADDR_W'(base) + ADDR_W'(1);
      hi_mask_o = {pat_i[3:0], 4'h0};
    end else begin
      lo_addr_o = ADDR_W'(base) - ADDR_W'(1);
      lo_mask_o = {4'h0, pat_i[11:8]};
      hi_addr_o = ADDR_W'(base);
      hi_mask_o = pat_i[7:0];
    end
  end

  // symbol 0: top nibble sits before the stream start
  assign lo_skip_o = (idx_i == '0);
endmodule

// File: rtl/rsa_screen.sv
module rsa_screen #(
  parameter int MAX_ERR = 4,
  parameter int IDX_W   = 11,
  parameter int CNT_W   = 4,
  parameter int CW_LEN  = 1367
) (
  input  logic                     fail_i,
  input  logic [CNT_W-1:0]         count_i,
  input  logic [MAX_ERR*IDX_W-1:0] loc_i,
  input  logic [MAX_ERR-1:0]       vld_i,
  output logic [MAX_ERR-1:0]       active_o,
  output logic                     reject_o
);
  logic [MAX_ERR-1:0] range_bad;

  for (genvar g = 0; g < MAX_ERR; g++) begin : g_slot
    assign active_o[g]  = vld_i[g] && (count_i > CNT_W'(g));
    assign range_bad[g] = active_o[g] &&
                          (loc_i[g*IDX_W +: IDX_W] > IDX_W'(CW_LEN - 1));
  end

  assign reject_o = fail_i || (count_i > CNT_W'(MAX_ERR)) || (|range_bad);
endmodule

// File: rtl/rsa_seq.sv
module rsa_seq
  import rsa_pkg::*;
#(
  parameter int MAX_ERR = 4,
  parameter int PTR_W   = 3,
  parameter int SEL_W   = 2,
  parameter int ADDR_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              reject_i,
  input  logic [MAX_ERR-1:0] active_i,
  input  logic [ADDR_W-1:0] lo_addr_i,
  input  logic [BYTE_W-1:0] lo_mask_i,
  input  logic [ADDR_W-1:0] hi_addr_i,
  input  logic [BYTE_W-1:0] hi_mask_i,
  input  logic              lo_skip_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              uncorr_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o
);
  localparam int EXT = 1 << PTR_W;

  rsa_state_e       state_q;
  logic [PTR_W-1:0] ptr_q;
  logic             uncorr_q;
  logic [EXT-1:0]   act_ext;
  logic             ptr_end;
  logic             use_lo;

  assign act_ext = EXT'(active_i);
  assign ptr_end = (ptr_q == PTR_W'(MAX_ERR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      uncorr_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ptr_q    <= '0;
          uncorr_q <= reject_i;
          state_q  <= reject_i ? ST_DONE : ST_SCAN;
        end
        ST_SCAN: begin
          if (ptr_end)                state_q <= ST_DONE;
          else if (act_ext[ptr_q])    state_q <= lo_skip_i ? ST_RD_HI : ST_RD_LO;
          else                        ptr_q   <= ptr_q + PTR_W'(1);
        end
        ST_RD_LO: state_q <= ST_WR_LO;
        ST_WR_LO: state_q <= ST_RD_HI;
        ST_RD_HI: state_q <= ST_WR_HI;
        ST_WR_HI: begin
          ptr_q   <= ptr_q + PTR_W'(1);
          state_q <= ST_SCAN;
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign use_lo      = (state_q == ST_RD_LO) || (state_q == ST_WR_LO);
  assign mem_we_o    = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
  assign mem_en_o    = use_lo || (state_q == ST_RD_HI) || (state_q == ST_WR_HI);
  assign mem_addr_o  = use_lo ? lo_addr_i : hi_addr_i;
  assign mem_wdata_o = mem_rdata_i ^ (use_lo ? lo_mask_i : hi_mask_i);

  assign sel_o    = ptr_q[SEL_W-1:0];
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign uncorr_o = uncorr_q;
endmodule

// File: rtl/rs_err_apply.sv
module rs_err_apply
  import rsa_pkg::*;
#(
  parameter int MAX_ERR     = 4,
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int CW_LEN      = 1367,
  localparam int IDX_W  = $clog2(CW_LEN),
  localparam int ADDR_W = $clog2(PAGE_BYTES + SPARE_BYTES),
  localparam int CNT_W  = $clog2(MAX_ERR + 1) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     fail_i,
  input  logic [CNT_W-1:0]         count_i,
  input  logic [MAX_ERR*IDX_W-1:0] loc_i,
  input  logic [MAX_ERR*SYM_W-1:0] pat_i,
  input  logic [MAX_ERR-1:0]       vld_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     uncorr_o,
  output logic                     mem_en_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [BYTE_W-1:0]        mem_wdata_o,
  input  logic [BYTE_W-1:0]        mem_rdata_i
);
  localparam int PTR_W = $clog2(MAX_ERR + 1);
  localparam int SEL_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

  logic [MAX_ERR-1:0] active;
  logic               reject;
  logic [SEL_W-1:0]   sel;
  logic [IDX_W-1:0]   loc_arr [MAX_ERR];
  logic [SYM_W-1:0]   pat_arr [MAX_ERR];
  logic [ADDR_W-1:0]  lo_addr, hi_addr;
  logic [BYTE_W-1:0]  lo_mask, hi_mask;
  logic               lo_skip;

  for (genvar g = 0; g < MAX_ERR; g++) begin : g_unpack
    assign loc_arr[g] = loc_i[g*IDX_W +: IDX_W];
    assign pat_arr[g] = pat_i[g*SYM_W +: SYM_W];
  end

  rsa_screen #(
    .MAX_ERR(MAX_ERR), .IDX_W(IDX_W), .CNT_W(CNT_W), .CW_LEN(CW_LEN)
  ) u_screen (
    .fail_i   (fail_i),
    .count_i  (count_i),
    .loc_i    (loc_i),
    .vld_i    (vld_i),
    .active_o (active),
    .reject_o (reject)
  );

  rsa_sym_map #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_map (
    .idx_i     (loc_arr[sel]),
    .pat_i     (pat_arr[sel]),
    .lo_addr_o (lo_addr),
    .lo_mask_o (lo_mask),
    .hi_addr_o (hi_addr),
    .hi_mask_o (hi_mask),
    .lo_skip_o (lo_skip)
  );

  rsa_seq #(
    .MAX_ERR(MAX_ERR), .PTR_W(PTR_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .reject_i    (reject),
    .active_i    (active),
    .lo_addr_i   (lo_addr),
    .lo_mask_i   (lo_mask),
    .hi_addr_i   (hi_addr),
    .hi_mask_i   (hi_mask),
    .lo_skip_i   (lo_skip),
    .mem_rdata_i (mem_rdata_i),
    .sel_o       (sel),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .uncorr_o    (uncorr_o),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );
endmodule

// File: rtl/rs_err_apply_chk.sv
module rs_err_apply_chk #(
  parameter int MAX_ERR     = 4,
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int CW_LEN      = 1367,
  localparam int IDX_W  = $clog2(CW_LEN),
  localparam int ADDR_W = $clog2(PAGE_BYTES + SPARE_BYTES),
  localparam int CNT_W  = $clog2(MAX_ERR + 1) + 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     fail_i,
  input logic [CNT_W-1:0]         count_i,
  input logic [MAX_ERR*IDX_W-1:0] loc_i,
  input logic [MAX_ERR*12-1:0]    pat_i,
  input logic [MAX_ERR-1:0]       vld_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic                     uncorr_o,
  input logic                     mem_en_o,
  input logic                     mem_we_o,
  input logic [ADDR_W-1:0]        mem_addr_o
);
  logic wrote_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  wrote_q <= 1'b0;
    else if (start_i && !busy_o)  wrote_q <= 1'b0;
    else if (mem_en_o && mem_we_o) wrote_q <= 1'b1;
  end

  // R7
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !mem_we_o) |=> (mem_en_o && mem_we_o && mem_addr_o == $past(mem_addr_o)));

  // R7
  no_wr_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && mem_we_o) |=> !(mem_en_o && mem_we_o));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_en_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  reject_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && uncorr_o) |-> !wrote_q);

  // R4
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (mem_addr_o < ADDR_W'(PAGE_BYTES + SPARE_BYTES)));

  // R5
  stable_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      ($stable(loc_i) && $stable(pat_i) && $stable(vld_i) &&
       $stable(count_i) && $stable(fail_i)));
endmodule

bind rs_err_apply rs_err_apply_chk #(
  .MAX_ERR(MAX_ERR), .PAGE_BYTES(PAGE_BYTES),
  .SPARE_BYTES(SPARE_BYTES), .CW_LEN(CW_LEN)
) u_chk (.*);

// File: tb/tb_rs_err_apply.sv
module tb_rs_err_apply;
  localparam int MAX_ERR = 4;
  localparam int IDX_W   = 11;
  localparam int ADDR_W  = 12;
  localparam int CNT_W   = 4;
  localparam int TOTAL   = 2048 + 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, fail = 1'b0;
  logic [CNT_W-1:0] count = '0;
  logic [MAX_ERR*IDX_W-1:0] loc = '0;
  logic [MAX_ERR*12-1:0] pat = '0;
  logic [MAX_ERR-1:0] vld = '0;
  logic busy, done, uncorr, mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;

  always #4 clk = ~clk;

  rs_err_apply dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fail_i(fail),
    .count_i(count), .loc_i(loc), .pat_i(pat), .vld_i(vld),
    .busy_o(busy), .done_o(done), .uncorr_o(uncorr),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  logic [7:0] mem [TOTAL];
  logic [7:0] exp_mem [TOTAL];
  int wr_log [16];
  int wr_cnt = 0;
  logic init_req = 1'b0;

  function automatic logic [7:0] init_val(int k);
    return 8'((k * 37 + 5) ^ (k >> 3));
  endfunction

  always @(posedge clk) begin
    if (init_req) begin
      for (int k = 0; k < TOTAL; k++) mem[k] <= init_val(k);
      wr_cnt <= 0;
    end else if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        if (wr_cnt < 16) wr_log[wr_cnt] <= int'(mem_addr);
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  int vectors = 0, misses = 0;
  bit finished = 1'b0;

  task automatic check(string req, string what, int act, int expv);
    vectors++;
    if (act != expv) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  int e_loc [MAX_ERR];
  int e_pat [MAX_ERR];
  bit e_vld [MAX_ERR];

  task automatic set_entry(int s, int l, int p, bit v);
    e_loc[s] = l; e_pat[s] = p; e_vld[s] = v;
  endtask

  task automatic clear_entries();
    for (int s = 0; s < MAX_ERR; s++) set_entry(s, 0, 0, 1'b0);
  endtask

  // expected result from the MSB-first bit-stream view
  task automatic run_case(string req, bit f, int cnt);
    int exp_log [16];
    int n_exp;
    bit rej;
    int bad;
    int waited;
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    rej = f || (cnt > MAX_ERR);
    for (int s = 0; s < MAX_ERR; s++)
      if (s < cnt && e_vld[s] && e_loc[s] > 1366) rej = 1'b1;
    for (int k = 0; k < TOTAL; k++) exp_mem[k] = init_val(k);
    n_exp = 0;
    if (!rej) begin
      for (int s = 0; s < MAX_ERR; s++) begin
        if (s < cnt && e_vld[s]) begin
          int first, last;
          for (int b = 0; b < 12; b++) begin
            int pos;
            pos = 12 * e_loc[s] - 4 + b;
            if (pos >= 0 && e_pat[s][11 - b])
              exp_mem[pos >> 3][7 - (pos & 7)] ^= 1'b1;
          end
          first = (12 * e_loc[s] - 4 < 0) ? 0 : (12 * e_loc[s] - 4) >> 3;
          last  = (12 * e_loc[s] + 7) >> 3;
          exp_log[n_exp++] = first;
          if (last != first) exp_log[n_exp++] = last;
        end
      end
    end
    fail = f;
    count = CNT_W'(cnt);
    for (int s = 0; s < MAX_ERR; s++) begin
      loc[s*IDX_W +: IDX_W] = IDX_W'(e_loc[s]);
      pat[s*12 +: 12] = 12'(e_pat[s]);
      vld[s] = e_vld[s];
    end
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9", {req, " busy after start"}, int'(busy), 1);
    waited = 0;
    while (!done && waited < 200) begin
      @(negedge clk); waited++;
    end
    check("R9", {req, " done seen"}, int'(done), 1);
    check("R6", {req, " uncorr with done"}, int'(uncorr), int'(rej));
    @(negedge clk);
    check("R9", {req, " done single cycle"}, int'(done), 0);
    check("R9", {req, " idle after done"}, int'(busy), 0);
    bad = 0;
    for (int k = 0; k < TOTAL; k++) if (mem[k] !== exp_mem[k]) bad++;
    check(req, "page bytes differing", bad, 0);
    check(req, "write count", wr_cnt, n_exp);
    for (int i = 0; i < n_exp && i < 16; i++)
      check("R8", {req, " write order"}, wr_log[i], exp_log[i]);
  endtask

  // R1
  task automatic t_odd();
    clear_entries(); set_entry(0, 7, 'hABC, 1'b1); run_case("R1", 1'b0, 1);
    clear_entries(); set_entry(0, 1001, 'h0F1, 1'b1); run_case("R1", 1'b0, 1);
  endtask
  // R2
  task automatic t_even();
    clear_entries(); set_entry(0, 10, 'h5A3, 1'b1); run_case("R2", 1'b0, 1);
  endtask
  // R3
  task automatic t_sym0();
    clear_entries(); set_entry(0, 0, 'hFFF, 1'b1); run_case("R3", 1'b0, 1);
  endtask
  // R4
  task automatic t_boundary();
    clear_entries(); set_entry(0, 1365, 'h9C7, 1'b1); run_case("R4", 1'b0, 1);
    clear_entries(); set_entry(0, 1364, 'h248, 1'b1);
    set_entry(1, 1366, 'h3E1, 1'b1); run_case("R4", 1'b0, 2);
  endtask
  // R5 / R8: shared bytes between neighbours
  task automatic t_four();
    clear_entries();
    set_entry(0, 100, 'h123, 1'b1); set_entry(1, 101, 'hF0F, 1'b1);
    set_entry(2, 102, 'h801, 1'b1); set_entry(3, 500, 'hFFF, 1'b1);
    run_case("R5", 1'b0, 4);
  endtask
  // R5
  task automatic t_skip();
    clear_entries();
    set_entry(0, 20, 'h111, 1'b1); set_entry(1, 21, 'h222, 1'b0);
    set_entry(2, 30, 'h333, 1'b1); set_entry(3, 40, 'h444, 1'b1);
    run_case("R5", 1'b0, 3);
    clear_entries(); set_entry(0, 50, 'hAAA, 1'b1); run_case("R5", 1'b0, 0);
  endtask
  // R6
  task automatic t_reject();
    clear_entries(); set_entry(0, 9, 'h777, 1'b1); run_case("R6", 1'b0, 5);
    clear_entries(); set_entry(0, 9, 'h777, 1'b1); run_case("R6", 1'b1, 1);
    clear_entries(); set_entry(0, 9, 'h777, 1'b1);
    set_entry(1, 1367, 'h777, 1'b1); run_case("R6", 1'b0, 2);
    clear_entries(); set_entry(0, 9, 'h777, 1'b1);
    set_entry(1, 2000, 'h777, 1'b0); run_case("R6", 1'b0, 2);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    check("R10", "busy at reset", int'(busy), 0);
    check("R10", "done at reset", int'(done), 0);
    check("R10", "uncorr at reset", int'(uncorr), 0);
    check("R10", "mem_en at reset", int'(mem_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "no access while idle", int'(mem_en), 0);
    t_odd();
    t_even();
    t_sym0();
    t_boundary();
    t_four();
    t_skip();
    t_reject();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule